// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked monostable: a qualifying input edge drives the output `q` high for a programmed number of clock cycles. `q_n` always carries the inverse of `q`. The timing is set by a cycle count on the `pulse_width` input, so no analog timing network is needed. A second trigger that arrives while the pulse runs starts the full count again. Triggers that keep coming can therefore hold `q` high for as long as they last.

Three asynchronous inputs can start the pulse, and each one is qualified by the other two:
- `trig_fall_n` responds to its falling edge.
- `trig_rise` responds to its rising edge.
- `clear_n`, the active-low clear, responds to its release.

While `clear_n` is held low, any running pulse stops and every trigger is refused. Each input passes through a two-flop synchroniser, and edges are found by comparing the synchronised level against its value one clock earlier.

The controller has three states. `S_IDLE` means no pulse. `S_RUN` means a pulse is being counted. `S_CLEAR` means the clear is being held. The named transitions are:
- FIRE: `S_IDLE` to `S_RUN`.
- EXTEND: `S_RUN` to `S_RUN`, which reloads the count.
- EXPIRE: `S_RUN` to `S_IDLE`.
- ABORT: any state to `S_CLEAR` when the clear is seen low.
- RELEASE: `S_CLEAR` to `S_IDLE`.
- REARM: `S_CLEAR` to `S_RUN`, when the release of the clear is itself a qualified trigger.

Top module: `retrig_oneshot`

## Requirements
- R1: While `rst` is high, and for the cycles after it falls, `q` is 0 and `q_n` is 1. No edge may be reported until the synchroniser and edge history hold real input values. In particular, inputs that sit at `trig_fall_n`=0, `trig_rise`=1, `clear_n`=1 across reset release produce no pulse.
- R2: A falling edge on `trig_fall_n` while `trig_rise`=1 and `clear_n`=1 starts a pulse. If the input changes just after clock edge k, `q` is low after edges k+1 and k+2 and is high after edge k+3. The pulse lasts exactly `pulse_width` cycles.
- R3: A rising edge on `trig_rise` while `trig_fall_n`=0 and `clear_n`=1 starts a pulse of `pulse_width` cycles.
- R4: A rising edge on `clear_n` while `trig_fall_n`=0 and `trig_rise`=1 starts a pulse of `pulse_width` cycles.
- R5: An edge whose other two inputs do not qualify it produces no pulse. Two examples are a rising edge of `trig_rise` with `trig_fall_n`=1, and a falling edge of `trig_fall_n` with `trig_rise`=0. Opposite-direction edges never trigger.
- R6: A trigger accepted during a pulse reloads the full width. A retrigger that arrives d cycles after the first trigger gives one pulse of d + `pulse_width` cycles.
- R7: A trigger that reaches the counter in the last cycle of a pulse extends it with no low cycle, giving 2×`pulse_width`. A trigger one cycle later gives two separate pulses with exactly one low cycle between them.
- R8: Bringing `clear_n` low ends a running pulse after the same three-edge latency that triggers have. While it stays low, no trigger of any kind is accepted. Releasing it when it is not qualified gives no pulse.
- R9: `q_n` is the complement of `q` in every cycle.
- R10: When `pulse_width`=0, a trigger produces no pulse. When `pulse_width`=1, a trigger produces a pulse of one cycle. The width is sampled when each trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| trig_fall_n | input | 1 | Trigger on falling edge (asynchronous) |
| trig_rise | input | 1 | Trigger on rising edge (asynchronous) |
| clear_n | input | 1 | Active-low clear; its rising edge can also trigger (asynchronous) |
| pulse_width | input | WIDTH | Pulse length in clock cycles |
| q | output | 1 | Pulse output, high while the pulse runs |
| q_n | output | 1 | Complement of q |

## Verification
The hardest case to reach from the ports is a retrigger that lands in exactly the terminal cycle of the count. Without careful timing, such a retrigger shows up as a short low gap on `q`. The stimulus reaches it by driving a second `trig_rise` rising edge exactly `pulse_width` cycles after the first, with the input dropped low in between. It then repeats the sequence one cycle later, so that the scoreboard expects one doubled pulse in the first run and two pulses in the second. The REARM path is reached the same way: `clear_n` is held low while the other two inputs are moved into the qualifying levels, so that the release itself becomes the trigger.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_CLEAR = 2'd2
    } os_state_e;

    localparam int IN_A   = 0;  // falling-edge trigger
    localparam int IN_B   = 1;  // rising-edge trigger
    localparam int IN_R   = 2;  // active-low clear
    localparam int NUM_IN = 3;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/os_trig_gate.sv
module os_trig_gate
    import oneshot_pkg::*;
#(
    parameter int SETTLE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] lvl,
    output logic              go,
    output logic              clr_ok
);

    localparam int CW = $clog2(SETTLE + 1);

    logic [NUM_IN-1:0] prev_q;
    logic [CW-1:0]     settle_q;
    logic              ready;
    logic              fall_a, rise_b, rise_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            settle_q <= '0;
        end else begin
            prev_q <= lvl;
            if (!ready) settle_q <= settle_q + CW'(1);
        end
    end

    always_comb begin
        ready  = (settle_q == CW'(SETTLE));
        fall_a = prev_q[IN_A] & ~lvl[IN_A];
        rise_b = ~prev_q[IN_B] & lvl[IN_B];
        rise_r = ~prev_q[IN_R] & lvl[IN_R];
        go     = ready & ((fall_a & lvl[IN_B] & lvl[IN_R]) |
                          (rise_b & ~lvl[IN_A] & lvl[IN_R]) |
                          (rise_r & ~lvl[IN_A] & lvl[IN_B]));
        clr_ok = lvl[IN_R];
    end

    AST_GO_NEEDS_CLEAR_HIGH: assert property (@(posedge clk) disable iff (rst)
        go |-> clr_ok);  // R8

endmodule

// File: rtl/os_pulse_fsm.sv
module os_pulse_fsm
    import oneshot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             clr_ok,
    input  logic [WIDTH-1:0] width,
    output logic             run
);

    os_state_e        state_q, state_d;
    logic [WIDTH-1:0] cnt_q, cnt_d;
    logic             load_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        load_ok = go && (width != '0);
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (!clr_ok) begin                // ABORT
                    state_d = S_CLEAR;
                end else if (load_ok) begin       // FIRE
                    state_d = S_RUN;
                    cnt_d   = width;
                end
            end
            S_RUN: begin
                if (!clr_ok) begin                // ABORT
                    state_d = S_CLEAR;
                    cnt_d   = '0;
                end else if (load_ok) begin       // EXTEND
                    cnt_d   = width;
                end else if (go || cnt_q == WIDTH'(1)) begin  // EXPIRE
                    state_d = S_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q - WIDTH'(1);
                end
            end
            S_CLEAR: begin
                if (clr_ok) begin
                    if (load_ok) begin            // REARM
                        state_d = S_RUN;
                        cnt_d   = width;
                    end else begin                // RELEASE
                        state_d = S_IDLE;
                    end
                end
            end
            default: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        run = (state_q == S_RUN);
    end

    AST_CLEAR_ENTRY: assert property (@(posedge clk) disable iff (rst)
        !clr_ok |=> state_q == S_CLEAR);  // R8
    AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && width == '0) |=> state_q != S_RUN);  // R10
    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (rst)
        (clr_ok && go && width != '0) |=> cnt_q == $past(width));  // R6
    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RUN && cnt_q == WIDTH'(1) && go && clr_ok && width != '0)
        |=> state_q == S_RUN);  // R7
    AST_RUN_COUNT_LIVE: assert property (@(posedge clk) disable iff (rst)
        state_q == S_RUN |-> cnt_q != '0);  // R10

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_fall_n,
    input  logic             trig_rise,
    input  logic             clear_n,
    input  logic [WIDTH-1:0] pulse_width,
    output logic             q,
    output logic             q_n
);

    localparam int SETTLE = SYNC_STAGES + 1;

    logic [NUM_IN-1:0] raw_in, sync_in;
    logic              go, clr_ok, run;

    always_comb begin
        raw_in       = '0;
        raw_in[IN_A] = trig_fall_n;
        raw_in[IN_B] = trig_rise;
        raw_in[IN_R] = clear_n;
    end

    os_sync #(.N(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_in)
    );

    os_trig_gate #(.SETTLE(SETTLE)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .lvl    (sync_in),
        .go     (go),
        .clr_ok (clr_ok)
    );

    os_pulse_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .clr_ok(clr_ok),
        .width (pulse_width),
        .run   (run)
    );

    always_comb begin
        q   = run;
        q_n = ~run;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !q);  // R1

endmodule

// File: tb/test_retrig_oneshot.sv
module test_retrig_oneshot;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         trig_fall_n = 1'b0;
    logic         trig_rise = 1'b1;
    logic         clear_n = 1'b1;
    logic [W-1:0] pulse_width = W'(8);
    logic         q, q_n;

    typedef struct {
        string tag;
        int    len;
    } exp_t;

    exp_t  exp_q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    int    run_len = 0;
    int    comp_err = 0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    retrig_oneshot #(.WIDTH(W), .SYNC_STAGES(2)) i_retrig_oneshot (
        .clk(clk), .rst(rst), .trig_fall_n(trig_fall_n), .trig_rise(trig_rise),
        .clear_n(clear_n), .pulse_width(pulse_width), .q(q), .q_n(q_n)
    );

    task automatic check(input string tag, input int act, input int expv, input string what);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic expect_pulse(input string tag, input int len);
        exp_t e;
        e.tag = tag;
        e.len = len;
        exp_q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle(input string tag, input int n);
        tick(n);
        check(tag, exp_q.size(), 0, "expected pulses still outstanding");
        exp_q.delete();
    endtask

    // monitor: measures each pulse and compares it with the scoreboard
    always @(negedge clk) begin
        if (rst) begin
            run_len = 0;
        end else begin
            if (q_n !== ~q) comp_err++;
            if (q) begin
                run_len++;
            end else if (run_len > 0) begin
                if (exp_q.size() == 0) begin
                    check(cur_tag, run_len, 0, "unexpected pulse length");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, run_len, e.len, "pulse length");
                end
                run_len = 0;
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : driver
        // R1: reset state, qualifying levels held across release
        tick(3);
        check("R1", int'(q), 0, "q during reset");
        check("R1", int'(q_n), 1, "q_n during reset");
        rst = 1'b0;
        tick(1);
        check("R1", int'(q), 0, "q just after reset");
        settle("R1", 12);
        trig_fall_n = 1'b1;
        trig_rise   = 1'b0;
        settle("R1", 6);

        // R5: B rises with A high -> nothing
        cur_tag = "R5";
        trig_rise = 1'b1;
        settle("R5", 12);

        // R2: A falls with B high; latency then width
        cur_tag = "R2";
        expect_pulse("R2", 8);
        trig_fall_n = 1'b0;
        tick(2);
        check("R2", int'(q), 0, "q two edges after A fall");
        tick(1);
        check("R2", int'(q), 1, "q three edges after A fall");
        settle("R2", 15);

        // R3: B rises with A low
        cur_tag = "R3";
        trig_rise = 1'b0;
        settle("R3", 6);
        expect_pulse("R3", 8);
        trig_rise = 1'b1;
        settle("R3", 15);

        // R5: unqualified edges
        cur_tag = "R5";
        trig_fall_n = 1'b1;  tick(4);
        trig_rise   = 1'b0;  tick(4);
        trig_rise   = 1'b1;  tick(4);
        trig_rise   = 1'b0;  tick(4);
        trig_fall_n = 1'b0;  // A falls with B low
        settle("R5", 12);

        // R4 and R8: B rises under clear (blocked), release fires (REARM)
        cur_tag = "R8";
        clear_n = 1'b0;     tick(5);
        trig_rise = 1'b1;   tick(6);
        check("R8", int'(q), 0, "q with trigger under clear");
        cur_tag = "R4";
        expect_pulse("R4", 8);
        clear_n = 1'b1;
        settle("R4", 15);

        // R6: retrigger 5 cycles after the first
        cur_tag = "R6";
        trig_rise = 1'b0;  tick(5);
        expect_pulse("R6", 13);
        trig_rise = 1'b1;  tick(2);
        trig_rise = 1'b0;  tick(3);
        trig_rise = 1'b1;
        settle("R6", 22);
        trig_rise = 1'b0;  tick(5);

        // R7: retrigger lands in the terminal cycle -> one doubled pulse
        cur_tag = "R7";
        expect_pulse("R7", 16);
        trig_rise = 1'b1;  tick(2);
        trig_rise = 1'b0;  tick(6);
        trig_rise = 1'b1;
        settle("R7", 26);
        trig_rise = 1'b0;  tick(5);

        // R7: one cycle later -> two pulses with a gap
        expect_pulse("R7", 8);
        expect_pulse("R7", 8);
        trig_rise = 1'b1;  tick(2);
        trig_rise = 1'b0;  tick(7);
        trig_rise = 1'b1;
        settle("R7", 26);
        trig_rise = 1'b0;  tick(5);

        // R8: clear cuts a long pulse, blocks an A fall, silent release
        cur_tag = "R8";
        pulse_width = W'(20);
        expect_pulse("R8", 5);
        trig_rise = 1'b1;   tick(5);
        clear_n = 1'b0;     tick(6);
        check("R8", int'(q), 0, "q after clear fell");
        trig_fall_n = 1'b1; tick(4);
        trig_fall_n = 1'b0; tick(6);
        check("R8", int'(q), 0, "q after A fall under clear");
        trig_rise = 1'b0;   tick(4);
        trig_fall_n = 1'b1; tick(4);
        clear_n = 1'b1;
        settle("R8", 30);

        // R10: zero width gives nothing, width one gives one cycle
        cur_tag = "R10";
        pulse_width = W'(0);
        trig_fall_n = 1'b0; tick(4);
        trig_rise = 1'b1;
        settle("R10", 15);
        trig_rise = 1'b0;   tick(5);
        pulse_width = W'(1);
        expect_pulse("R10", 1);
        trig_rise = 1'b1;
        settle("R10", 10);
        trig_rise = 1'b0;   tick(5);
        pulse_width = W'(255);
        expect_pulse("R10", 255);
        trig_rise = 1'b1;
        settle("R10", 265);

        // R9: complement held on every sampled cycle
        check("R9", comp_err, 0, "cycles with q_n not equal to ~q");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule